// File: doc/BRIEF.md
# Hierarchical Single-Vector Interrupt Controller

This block gathers event pulses from a set of peripheral modules. It keeps one sticky flag for each source and produces one interrupt request. Each module owns a group of sources. A source can reach the request line only when three switches are all on: its own enable, the enable of its module, and one global enable. Flags latch whatever the enables are doing. Software therefore sees every event that happened, even when that event was masked at the time.

All interrupts share one programmable vector register. After the handler is entered, software reads the identification output or flag registers to find which module to serve. It then clears the flags by writing ones to them.

Some modules are synchronous and carry one extra pipeline stage. After a flag is set or cleared, the request follows one cycle later for an asynchronous module and two cycles later for a synchronous one.

Top module: `ic_irq_ctrl`

## Requirements
- R1: `irq_o` is high only if some source has its flag, its individual enable, its module enable and the global enable all set. The global enable is bit 0 at address 1, and the module enable mask sits at address 2 with bit m for module m.
- R2: An event pulse on `evt_i[m*N_SRC+s]` sets the flag of source s in module m, whatever the state of the enables. Module m's flags read back at address 8+m.
- R3: Writing a one to a bit at address 8+m clears that flag. Writing a zero leaves the bit unchanged. The individual enables of module m are at address 16+m.
- R4: If an event and a clear of the same flag land in the same cycle, the flag ends up set.
- R5: The vector register resets to 0x0000. It is written at address 0 and shows on `vector_o`, and it reads back at address 0.
- R6: `ident_o[m]` is high when module m has a flag whose individual enable and module enable are both set. The global enable does not gate it.
- R7: For asynchronous modules, `irq_o` and `ident_o` follow a flag change one clock later. For synchronous modules (modules 2 and 3 by default) they follow two clocks later.
- R8: After reset, all flags, all enables, `irq_o` and `ident_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_MOD*N_SRC | Source event pulses, module-major order |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Single interrupt request |
| vector_o | output | DATA_W | Shared interrupt vector |
| ident_o | output | N_MOD | Modules with enabled pending interrupts |

## Verification
Some properties are checked on every cycle by assertions:
- an event always leaves its flag set;
- a flag never falls without a matching clear;
- the request never rises without the global enable;
- a raised request always has a module in the identification output;
- the vector moves only on a write.

Other behaviour can only be shown by the bench's scenarios:
- the exact one-cycle and two-cycle latencies;
- the way the three enable levels combine across modules;
- write-zero having no effect;
- an event that collides with a clear.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int ADR_VEC       = 0;
    localparam int ADR_GLOBAL_EN = 1;
    localparam int ADR_MODULE_EN = 2;
    localparam int ADR_FLAG_BASE = 8;
    localparam int ADR_IEN_BASE  = 16;
endpackage

// File: rtl/ic_src_bank.sv
module ic_src_bank #(
    parameter int N_SRC = 4,
    parameter bit SYNC  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             flag_wr_i,
    input  logic             ien_wr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic             men_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] ien_o,
    output logic             pend_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flags;
        logic [N_SRC-1:0] ien;
        logic             pend;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [N_SRC-1:0] clr_mask;
    logic             pend_now;

    always_comb begin
        clr_mask = flag_wr_i ? wdata_i : '0;
        pend_now = (|(st_q.flags & st_q.ien)) & men_i;
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_mask) | evt_i;
        if (ien_wr_i) st_d.ien = wdata_i;
        st_d.pend  = pend_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign ien_o   = st_q.ien;
    assign pend_o  = SYNC ? st_q.pend : pend_now;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_q.flags & $past(evt_i)) == $past(evt_i))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_q.flags & ($past(st_q.flags) & ~$past(clr_mask)))
                          == ($past(st_q.flags) & ~$past(clr_mask)))); // R3
endmodule

// File: rtl/ic_irq_ctrl.sv
module ic_irq_ctrl
    import ic_pkg::*;
#(
    parameter int          N_MOD     = 4,
    parameter int          N_SRC     = 4,
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 5,
    parameter logic [7:0]  SYNC_MODS = 8'b0000_1100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MOD*N_SRC-1:0] evt_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   irq_o,
    output logic [DATA_W-1:0]      vector_o,
    output logic [N_MOD-1:0]       ident_o
);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(ADR_VEC);
    localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(ADR_GLOBAL_EN);
    localparam logic [ADDR_W-1:0] A_MEN = ADDR_W'(ADR_MODULE_EN);

    typedef struct packed {
        logic [DATA_W-1:0] vec;
        logic              glob;
        logic [N_MOD-1:0]  men;
        logic              irq;
        logic [N_MOD-1:0]  ident;
    } top_st_t;

    top_st_t                     st_d, st_q;
    logic [N_MOD-1:0][N_SRC-1:0] flags_w, ien_w;
    logic [N_MOD-1:0]            pend_w, flag_wr, ien_wr;

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        assign flag_wr[m] = wr_en_i && (wr_addr_i == ADDR_W'(ADR_FLAG_BASE + m));
        assign ien_wr[m]  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_IEN_BASE + m));

        ic_src_bank #(.N_SRC(N_SRC), .SYNC(SYNC_MODS[m])) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[m*N_SRC +: N_SRC]),
            .flag_wr_i(flag_wr[m]),
            .ien_wr_i (ien_wr[m]),
            .wdata_i  (wr_data_i[N_SRC-1:0]),
            .men_i    (st_q.men[m]),
            .flags_o  (flags_w[m]),
            .ien_o    (ien_w[m]),
            .pend_o   (pend_w[m])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_addr_i == A_VEC) st_d.vec  = wr_data_i;
        if (wr_en_i && wr_addr_i == A_GEN) st_d.glob = wr_data_i[0];
        if (wr_en_i && wr_addr_i == A_MEN) st_d.men  = wr_data_i[N_MOD-1:0];
        st_d.ident = pend_w;
        st_d.irq   = st_q.glob & (|pend_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_VEC) rd_data_o = st_q.vec;
        if (rd_addr_i == A_GEN) rd_data_o[0] = st_q.glob;
        if (rd_addr_i == A_MEN) rd_data_o[N_MOD-1:0] = st_q.men;
        for (int m = 0; m < N_MOD; m++) begin
            if (rd_addr_i == ADDR_W'(ADR_FLAG_BASE + m)) rd_data_o[N_SRC-1:0] = flags_w[m];
            if (rd_addr_i == ADDR_W'(ADR_IEN_BASE + m))  rd_data_o[N_SRC-1:0] = ien_w[m];
        end
    end

    assign irq_o    = st_q.irq;
    assign vector_o = st_q.vec;
    assign ident_o  = st_q.ident;

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_o) |-> $past(st_q.glob)); // R1

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ident_o != '0)); // R6

    AST_VEC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en_i) && $past(wr_addr_i) == A_VEC)) |-> $stable(vector_o)); // R5
endmodule

// File: tb/ic_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ic_irq_ctrl_tb_top;
    localparam int NM = 4;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   evt = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [15:0]   rd_data, vector;
    logic          irq;
    logic [3:0]    ident;
    int            checks = 0;
    int            failures = 0;

    always #4 clk = ~clk;

    ic_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_o(irq), .vector_o(vector), .ident_o(ident)
    );

    // row: glob, module enables, individual enables (all modules), events, expected ident, expected irq
    typedef struct packed {
        logic        glob;
        logic [3:0]  men;
        logic [3:0]  ien;
        logic [15:0] evt;
        logic [3:0]  exp_ident;
        logic        exp_irq;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{1'b1, 4'hF, 4'hF, 16'h0001, 4'b0001, 1'b1},
        '{1'b0, 4'hF, 4'hF, 16'h0010, 4'b0010, 1'b0},
        '{1'b1, 4'hE, 4'hF, 16'h0001, 4'b0000, 1'b0},
        '{1'b1, 4'hF, 4'h2, 16'h0101, 4'b0000, 1'b0},
        '{1'b1, 4'hF, 4'h8, 16'h8008, 4'b1001, 1'b1},
        '{1'b1, 4'h4, 4'hF, 16'h0F00, 4'b0100, 1'b1}
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 5'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk);
        evt = e;
        @(posedge clk);
        @(negedge clk);
        evt = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R5 vector reset", int'(vector), 0);
        check("R8 irq reset", int'(irq), 0);
        check("R8 ident reset", int'(ident), 0);
        rd(8, v);  check("R8 flags reset", v, 0);
        rd(2, v);  check("R8 module enables reset", v, 0);
        rd(16, v); check("R8 individual enables reset", v, 0);

        // vector programming
        wr(0, 16'h1234);
        check("R5 vector_o", int'(vector), 16'h1234);
        rd(0, v); check("R5 vector readback", v, 16'h1234);

        // table walk
        foreach (ROWS[i]) begin
            for (int m = 0; m < NM; m++) wr(8 + m, 16'hF);
            for (int m = 0; m < NM; m++) wr(16 + m, int'(ROWS[i].ien));
            wr(2, int'(ROWS[i].men));
            wr(1, int'(ROWS[i].glob));
            pulse(ROWS[i].evt);
            repeat (3) step();
            check($sformatf("R6 row%0d ident", i), int'(ident), int'(ROWS[i].exp_ident));
            check($sformatf("R1 row%0d irq", i), int'(irq), int'(ROWS[i].exp_irq));
            for (int m = 0; m < NM; m++) begin
                rd(8 + m, v);
                check($sformatf("R2 row%0d flags m%0d", i, m), v, int'(ROWS[i].evt[m*NS +: NS]));
            end
        end

        // latency, asynchronous module 0
        for (int m = 0; m < NM; m++) wr(8 + m, 16'hF);
        for (int m = 0; m < NM; m++) wr(16 + m, 16'hF);
        wr(2, 16'hF);
        wr(1, 1);
        repeat (3) step();
        check("R7 idle irq", int'(irq), 0);
        pulse(16'h0001);
        check("R7 async set +1 not yet", int'(irq), 0);
        step();
        check("R7 async set +2", int'(irq), 1);
        check("R7 async ident", int'(ident), 4'b0001);
        wr(8, 1);
        check("R7 async clear edge", int'(irq), 1);
        step();
        check("R7 async clear +1", int'(irq), 0);

        // latency, synchronous module 3
        pulse(16'h1000);
        check("R7 sync set +1", int'(irq), 0);
        step();
        check("R7 sync set +2", int'(irq), 0);
        step();
        check("R7 sync set +3", int'(irq), 1);
        check("R7 sync ident", int'(ident), 4'b1000);
        wr(11, 1);
        check("R7 sync clear edge", int'(irq), 1);
        step();
        check("R7 sync clear +1", int'(irq), 1);
        step();
        check("R7 sync clear +2", int'(irq), 0);

        // write-one-to-clear semantics
        pulse(16'h0030);
        wr(9, 0);
        rd(9, v); check("R3 write zero keeps", v, 3);
        wr(9, 1);
        rd(9, v); check("R3 write one clears", v, 2);

        // event collides with clear
        @(negedge clk);
        evt = 16'h0020; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 16'h0002;
        @(posedge clk);
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        rd(9, v); check("R4 event beats clear", v, 2);

        // global disable gates irq but not ident
        wr(1, 0);
        repeat (3) step();
        check("R1 global off irq", int'(irq), 0);
        check("R6 ident ignores global", int'(ident), 4'b0010);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule